// File: doc/BRIEF.md
# Scatter Descriptor Table Builder

The block turns a stream of physical memory fragments (start address plus byte length) into a table of two-word DMA descriptors. Fragments whose start address equals the end of the run collected so far are merged into that run. Each run is then cut into chunks so that no chunk crosses a 64 KB address boundary, and every chunk becomes one descriptor. The descriptors go out through a write port that carries a table index, an address word and a count/flag word.

A request is a sequence of fragments ending with one that has its last flag set. When the request is finished the block pulses `done` with a status code and the number of descriptors in the table. The final descriptor carries an end-of-table flag. If the table would fill up, or the request holds no bytes at all, the block reports a failure status so that the caller can move the data with programmed I/O instead. Buffers are assumed to be 16-bit aligned.

Top module: `sg_desc_builder`

## Requirements
- R1: Each descriptor write carries the chunk start address on `desc_addr` and, on `desc_ctrl`, the byte count in bits 15:0, zeros in bits 30:16 and the end-of-table flag in bit 31.
- R2: No descriptor spans a 64 KB boundary: each chunk length is the smaller of the bytes left in the run and 0x10000 minus the low 16 bits of the chunk address.
- R3: A chunk of exactly 65536 bytes is written with a count field of 0.
- R4: A fragment whose start address equals the end address of the current run is merged into that run; any other fragment closes the run and starts a new one.
- R5: A fragment of length zero is ignored: it neither adds a descriptor nor breaks the merging of the fragments around it.
- R6: Descriptors of a request are written once each, in ascending index order starting at 0; only the last one has bit 31 set.
- R7: A successful request ends with `done` high for one cycle, `done_status` = 0 (ok) and `done_count` equal to the number of descriptors, in the same cycle as the end-of-table write.
- R8: A request that needs TBL_DEPTH or more descriptors ends with `done_status` = 1 (overflow) and `done_count` = 0; no end-of-table flag is written, the remaining fragments of the request are still accepted, and a request needing TBL_DEPTH-1 descriptors succeeds.
- R9: A request whose fragments hold no bytes ends with `done_status` = 2 (empty), `done_count` = 0 and no descriptor write.
- R10: After reset `frag_ready` is high and neither `desc_we` nor `done` is asserted.
- R11: Requests are independent: after any outcome, the next request starts its indices at 0 and does not merge with the previous request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Fragment accepted when high together with `frag_valid` |
| frag_addr | input | 32 | Fragment physical start address (bit 0 zero) |
| frag_len | input | LEN_W | Fragment length in bytes (bit 0 zero) |
| frag_last | input | 1 | Fragment is the final one of the request |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | $clog2(TBL_DEPTH) | Table index of the written descriptor |
| desc_addr | output | 32 | Descriptor address word |
| desc_ctrl | output | 32 | Descriptor count/flag word |
| done | output | 1 | One-cycle request completion pulse |
| done_status | output | 2 | 0 ok, 1 overflow, 2 empty |
| done_count | output | $clog2(TBL_DEPTH)+1 | Descriptors in the table (0 on failure) |

## Verification
A descriptor write appears on the port one clock after the chunk is cut, because each chunk is held back one step until it is known whether another follows, and the end-of-table write and `done` share one cycle after the final chunk is cut. The bench therefore does not predict absolute cycles: it builds, from the fragments alone, the ordered list of expected writes and the expected status, then on every falling edge compares any write against the head of that list and any `done` against the status, also requiring the list to be empty by then. Each request must finish within a bounded number of cycles, and directed requests cover boundary splits, exact 64 KB chunks, merging across zero-length fragments, the empty case and both sides of the table limit, followed by seeded random requests.

// File: rtl/sg_desc_pkg.sv
package sg_desc_pkg;

    typedef enum logic [1:0] {
        SGD_OK       = 2'd0,
        SGD_OVERFLOW = 2'd1,
        SGD_EMPTY    = 2'd2
    } sgd_status_e;

    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_SPLIT   = 2'd1,
        S_DRAIN   = 2'd2,
        S_FINISH  = 2'd3
    } sgd_fsm_e;

    localparam int          ADDR_W   = 32;
    localparam int          RUN_W    = 32;
    localparam int          SEG_W    = 16;
    localparam int          EOT_BIT  = 31;
    localparam logic [16:0] SEG_SPAN = 17'h10000;

endpackage

// File: rtl/sgd_chunk_calc.sv
module sgd_chunk_calc
    import sg_desc_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [RUN_W-1:0]  remain,
    output logic [16:0]       chunk,
    output logic              final_piece
);
    logic [16:0] room;

    always_comb begin
        room        = SEG_SPAN - {1'b0, cur_addr[SEG_W-1:0]};
        final_piece = remain <= {{(RUN_W-17){1'b0}}, room};
        chunk       = final_piece ? remain[16:0] : room;
    end
endmodule

// File: rtl/sgd_merge_check.sv
module sgd_merge_check
    import sg_desc_pkg::*;
(
    input  logic [ADDR_W-1:0] run_addr,
    input  logic [RUN_W-1:0]  run_len,
    input  logic [ADDR_W-1:0] frag_addr,
    output logic              adjacent
);
    logic [ADDR_W-1:0] run_end;

    always_comb begin
        run_end  = run_addr + run_len;
        adjacent = (run_len != '0) && (frag_addr == run_end);
    end
endmodule

// File: rtl/sg_desc_builder.sv
module sg_desc_builder
    import sg_desc_pkg::*;
#(
    parameter int LEN_W     = 24,
    parameter int TBL_DEPTH = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frag_valid,
    output logic                         frag_ready,
    input  logic [31:0]                  frag_addr,
    input  logic [LEN_W-1:0]             frag_len,
    input  logic                         frag_last,
    output logic                         desc_we,
    output logic [$clog2(TBL_DEPTH)-1:0] desc_idx,
    output logic [31:0]                  desc_addr,
    output logic [31:0]                  desc_ctrl,
    output logic                         done,
    output logic [1:0]                   done_status,
    output logic [$clog2(TBL_DEPTH):0]   done_count
);
    localparam int IDX_W = $clog2(TBL_DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TBL_DEPTH);

    typedef struct packed {
        sgd_fsm_e          st;
        logic [ADDR_W-1:0] run_addr;
        logic [RUN_W-1:0]  run_len;
        logic              pend_valid;
        logic              pend_last;
        logic [ADDR_W-1:0] pend_addr;
        logic [LEN_W-1:0]  pend_len;
        logic              final_seen;
        logic              hold_valid;
        logic [ADDR_W-1:0] hold_addr;
        logic [SEG_W-1:0]  hold_cnt;
        logic [CNT_W-1:0]  nchunks;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [31:0]       aw;
        logic [31:0]       cw;
        logic              done;
        sgd_status_e       dst;
        logic [CNT_W-1:0]  dcnt;
    } state_t;

    state_t q, d;

    logic [16:0] chunk;
    logic        final_piece;
    logic        adjacent;

    sgd_chunk_calc u_chunk (
        .cur_addr    (q.run_addr),
        .remain      (q.run_len),
        .chunk       (chunk),
        .final_piece (final_piece)
    );

    sgd_merge_check u_merge (
        .run_addr  (q.run_addr),
        .run_len   (q.run_len),
        .frag_addr (frag_addr),
        .adjacent  (adjacent)
    );

    assign frag_ready = (q.st == S_COLLECT) || (q.st == S_DRAIN);

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.done = 1'b0;

        unique case (q.st)
            S_COLLECT: begin
                if (frag_valid) begin
                    if (frag_len == '0) begin
                        if (frag_last) begin
                            d.final_seen = 1'b1;
                            d.st = (q.run_len != '0) ? S_SPLIT : S_FINISH;
                        end
                    end else if (q.run_len == '0) begin
                        d.run_addr = frag_addr;
                        d.run_len  = RUN_W'(frag_len);
                        if (frag_last) begin
                            d.final_seen = 1'b1;
                            d.st = S_SPLIT;
                        end
                    end else if (adjacent) begin
                        d.run_len = q.run_len + RUN_W'(frag_len);
                        if (frag_last) begin
                            d.final_seen = 1'b1;
                            d.st = S_SPLIT;
                        end
                    end else begin
                        d.pend_valid = 1'b1;
                        d.pend_last  = frag_last;
                        d.pend_addr  = frag_addr;
                        d.pend_len   = frag_len;
                        d.st = S_SPLIT;
                    end
                end
            end

            S_SPLIT: begin
                if ((q.nchunks + CNT_W'(1)) >= CNT_LIMIT) begin
                    d.run_len    = '0;
                    d.pend_valid = 1'b0;
                    d.hold_valid = 1'b0;
                    d.nchunks    = '0;
                    if (q.final_seen || (q.pend_valid && q.pend_last)) begin
                        d.final_seen = 1'b0;
                        d.done       = 1'b1;
                        d.dst        = SGD_OVERFLOW;
                        d.dcnt       = '0;
                        d.st         = S_COLLECT;
                    end else begin
                        d.st = S_DRAIN;
                    end
                end else begin
                    d.nchunks = q.nchunks + CNT_W'(1);
                    if (q.hold_valid) begin
                        d.we  = 1'b1;
                        d.idx = IDX_W'(q.nchunks - CNT_W'(1));
                        d.aw  = q.hold_addr;
                        d.cw  = {16'b0, q.hold_cnt};
                    end
                    d.hold_valid = 1'b1;
                    d.hold_addr  = q.run_addr;
                    d.hold_cnt   = chunk[SEG_W-1:0];
                    d.run_addr   = q.run_addr + ADDR_W'(chunk);
                    d.run_len    = q.run_len - RUN_W'(chunk);
                    if (final_piece) begin
                        if (q.pend_valid) begin
                            d.pend_valid = 1'b0;
                            d.run_addr   = q.pend_addr;
                            d.run_len    = RUN_W'(q.pend_len);
                            if (q.pend_last) begin
                                d.final_seen = 1'b1;
                                d.st = S_SPLIT;
                            end else begin
                                d.st = S_COLLECT;
                            end
                        end else if (q.final_seen) begin
                            d.st = S_FINISH;
                        end else begin
                            d.st = S_COLLECT;
                        end
                    end
                end
            end

            S_DRAIN: begin
                if (frag_valid && frag_last) begin
                    d.done = 1'b1;
                    d.dst  = SGD_OVERFLOW;
                    d.dcnt = '0;
                    d.st   = S_COLLECT;
                end
            end

            S_FINISH: begin
                d.done = 1'b1;
                if (q.hold_valid) begin
                    d.we   = 1'b1;
                    d.idx  = IDX_W'(q.nchunks - CNT_W'(1));
                    d.aw   = q.hold_addr;
                    d.cw   = {1'b1, 15'b0, q.hold_cnt};
                    d.dst  = SGD_OK;
                    d.dcnt = q.nchunks;
                end else begin
                    d.dst  = SGD_EMPTY;
                    d.dcnt = '0;
                end
                d.run_len    = '0;
                d.pend_valid = 1'b0;
                d.final_seen = 1'b0;
                d.hold_valid = 1'b0;
                d.nchunks    = '0;
                d.st         = S_COLLECT;
            end

            default: d.st = S_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign desc_we     = q.we;
    assign desc_idx    = q.idx;
    assign desc_addr   = q.aw;
    assign desc_ctrl   = q.cw;
    assign done        = q.done;
    assign done_status = q.dst;
    assign done_count  = q.dcnt;

endmodule

// File: rtl/sgd_checker.sv
module sgd_checker
    import sg_desc_pkg::*;
#(
    parameter int TBL_DEPTH = 256
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         desc_we,
    input logic [$clog2(TBL_DEPTH)-1:0] desc_idx,
    input logic [15:0]                  addr_lo,
    input logic [31:0]                  desc_ctrl,
    input logic                         done,
    input logic [1:0]                   done_status,
    input logic [$clog2(TBL_DEPTH):0]   done_count
);
    localparam int IDX_W = $clog2(TBL_DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic [17:0] seg_end;
    always_comb begin
        seg_end = {2'b0, addr_lo} +
                  ((desc_ctrl[15:0] == 16'h0) ? 18'h10000 : {2'b0, desc_ctrl[15:0]});
    end

    // R1: reserved bits of the count/flag word stay clear
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (desc_ctrl[30:16] == 15'h0));

    // R2: a descriptor never runs past its 64 KB segment
    p_no_cross_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (seg_end <= 18'h10000));

    // R7: the end-of-table write only comes with a successful completion
    p_eot_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && desc_ctrl[EOT_BIT]) |-> (done && done_status == SGD_OK));

    // R6: a successful completion carries the end-of-table write of the last index
    p_ok_has_eot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == SGD_OK) |->
        (desc_we && desc_ctrl[EOT_BIT] && done_count != '0 &&
         CNT_W'(desc_idx) == done_count - CNT_W'(1)));

    // R8: no index at or beyond the last table slot is ever written
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (CNT_W'(desc_idx) <= CNT_W'(TBL_DEPTH - 2)));

    // R9: a failed request reports no descriptors and writes nothing in that cycle
    p_fail_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status != SGD_OK) |-> (done_count == '0 && !desc_we));

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind sg_desc_builder sgd_checker #(.TBL_DEPTH(TBL_DEPTH)) u_sgd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_we     (desc_we),
    .desc_idx    (desc_idx),
    .addr_lo     (desc_addr[15:0]),
    .desc_ctrl   (desc_ctrl),
    .done        (done),
    .done_status (done_status),
    .done_count  (done_count)
);

// File: tb/sg_desc_builder_test.sv
module sg_desc_builder_test;
    localparam int DEPTH = 16;
    localparam int LEN_W = 24;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic             clk;
    logic             rst_n;
    logic             frag_valid;
    logic             frag_ready;
    logic [31:0]      frag_addr;
    logic [LEN_W-1:0] frag_len;
    logic             frag_last;
    logic             desc_we;
    logic [IDX_W-1:0] desc_idx;
    logic [31:0]      desc_addr;
    logic [31:0]      desc_ctrl;
    logic             done;
    logic [1:0]       done_status;
    logic [CNT_W-1:0] done_count;

    sg_desc_builder #(.LEN_W(LEN_W), .TBL_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .frag_valid(frag_valid), .frag_ready(frag_ready),
        .frag_addr(frag_addr), .frag_len(frag_len), .frag_last(frag_last),
        .desc_we(desc_we), .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_ctrl(desc_ctrl),
        .done(done), .done_status(done_status), .done_count(done_count)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] fq_a[$];
    longint      fq_l[$];
    logic [31:0] ex_a[$];
    logic [31:0] ex_c[$];
    int          ex_i[$];
    int          ex_status;
    int          ex_count;
    string       cur_tag;
    bit          got_done;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: merge, split, then derive writes and status.
    task automatic build_expect();
        longint      rl[$];
        logic [31:0] ra[$];
        logic [31:0] ca[$];
        longint      cl[$];
        logic [31:0] cur_a = 0;
        longint      cur_l = 0;
        int          n = 0;
        bit          ovf = 0;
        ex_a.delete(); ex_c.delete(); ex_i.delete();
        foreach (fq_a[k]) begin
            if (fq_l[k] == 0) continue;
            if (cur_l != 0 && fq_a[k] == cur_a + 32'(cur_l)) begin
                cur_l += fq_l[k];
            end else begin
                if (cur_l != 0) begin ra.push_back(cur_a); rl.push_back(cur_l); end
                cur_a = fq_a[k];
                cur_l = fq_l[k];
            end
        end
        if (cur_l != 0) begin ra.push_back(cur_a); rl.push_back(cur_l); end
        foreach (ra[r]) begin
            logic [31:0] a = ra[r];
            longint      l = rl[r];
            while (l > 0 && !ovf) begin
                longint room = 65536 - longint'(a & 32'hFFFF);
                longint c = (l < room) ? l : room;
                n++;
                if (n >= DEPTH) ovf = 1;
                else begin ca.push_back(a); cl.push_back(c); end
                a = a + 32'(c);
                l = l - c;
            end
        end
        if (ovf) begin
            for (int k = 0; k < DEPTH - 2; k++) begin
                ex_a.push_back(ca[k]); ex_c.push_back(32'(cl[k] & 16'hFFFF)); ex_i.push_back(k);
            end
            ex_status = 1; ex_count = 0;
        end else if (n == 0) begin
            ex_status = 2; ex_count = 0;
        end else begin
            foreach (ca[k]) begin
                ex_a.push_back(ca[k]);
                ex_c.push_back(32'(cl[k] & 16'hFFFF) | ((k == n - 1) ? 32'h8000_0000 : 32'h0));
                ex_i.push_back(k);
            end
            ex_status = 0; ex_count = n;
        end
    endtask

    // Every-clock comparison against the reference lists
    always @(negedge clk) begin
        if (rst_n) begin
            if (desc_we) begin
                if (ex_a.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected write (R6)", 64'(desc_idx), 0);
                end else begin
                    check(desc_idx == IDX_W'(ex_i[0]), cur_tag, "index R6 R11", 64'(desc_idx), 64'(ex_i[0]));
                    check(desc_addr == ex_a[0], cur_tag, "address word R1 R2", 64'(desc_addr), 64'(ex_a[0]));
                    check(desc_ctrl == ex_c[0], cur_tag, "count word R1 R3", 64'(desc_ctrl), 64'(ex_c[0]));
                    void'(ex_a.pop_front()); void'(ex_c.pop_front()); void'(ex_i.pop_front());
                end
            end
            if (done) begin
                check(done_status == 2'(ex_status), cur_tag, "status R7 R8 R9", 64'(done_status), 64'(ex_status));
                check(done_count == CNT_W'(ex_count), cur_tag, "count R7", 64'(done_count), 64'(ex_count));
                check(ex_a.size() == 0, cur_tag, "writes missing at done R6", 64'(ex_a.size()), 0);
                got_done = 1'b1;
            end
        end
    end

    task automatic add(input logic [31:0] a, input longint l);
        fq_a.push_back(a); fq_l.push_back(l);
    endtask

    task automatic run_req(input string tag);
        int wait_cnt = 0;
        cur_tag  = tag;
        build_expect();
        got_done = 1'b0;
        foreach (fq_a[k]) begin
            bit r;
            @(posedge clk); #1;
            frag_valid = 1'b1;
            frag_addr  = fq_a[k];
            frag_len   = LEN_W'(fq_l[k]);
            frag_last  = (k == fq_a.size() - 1);
            do begin
                @(negedge clk); r = frag_ready;
                @(posedge clk); #1;
            end while (!r);
            frag_valid = 1'b0;
        end
        while (!got_done && wait_cnt < 3000) begin
            @(posedge clk); wait_cnt++;
        end
        @(negedge clk);
        check(got_done, tag, "done seen R7", 64'(got_done), 1);
        fq_a.delete(); fq_l.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] a;
        rst_n = 1'b0; frag_valid = 1'b0; frag_addr = '0; frag_len = '0; frag_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(frag_ready == 1'b1, "R10", "ready in reset", 64'(frag_ready), 1);
        check(desc_we == 1'b0, "R10", "write in reset", 64'(desc_we), 0);
        check(done == 1'b0, "R10", "done in reset", 64'(done), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(frag_ready == 1'b1, "R10", "ready after reset", 64'(frag_ready), 1);

        // R1 R7: single fragment, one descriptor with end-of-table
        add(32'h0000_1000, 'h200); run_req("R1");
        // R2: fragment crossing a 64 KB boundary
        add(32'h0001_FF00, 'h400); run_req("R2");
        // R3: exact 64 KB pieces encode count 0
        add(32'h0003_0000, 'h10000); run_req("R3");
        add(32'h0004_0000, 'h20000); run_req("R3");
        // R4: two adjacent fragments merged, third separate
        add(32'h0000_5000, 'h800); add(32'h0000_5800, 'h800); add(32'h0000_9000, 'h100);
        run_req("R4");
        // R4: merged run that then crosses a boundary
        add(32'h0005_F000, 'h800); add(32'h0005_F800, 'h1000); run_req("R4");
        // R5: zero-length fragment in the middle does not break merging
        add(32'h0000_6000, 'h200); add(32'h0012_3450, 0); add(32'h0000_6200, 'h100);
        run_req("R5");
        // R9: only zero-length fragments
        add(32'h0000_0100, 0); run_req("R9");
        add(32'h0000_0100, 0); add(32'h0000_0800, 0); run_req("R9");
        // R8: fifteen descriptors fit (DEPTH-1)
        for (int k = 0; k < DEPTH - 1; k++) add(32'h0010_0000 + k * 32'h100, 'h10);
        run_req("R8");
        // R8: twenty descriptors overflow, remaining fragments drained
        for (int k = 0; k < 20; k++) add(32'h0020_0000 + k * 32'h100, 'h10);
        run_req("R8");
        // R8: overflow inside one large run, last fragment already seen
        add(32'h0030_0000, 'h110000); run_req("R8");
        // R11: fresh request after overflow, must not merge with previous
        add(32'h0020_1410, 'h40); run_req("R11");
        add(32'h0020_1450, 'h40); run_req("R11");

        // Seeded random requests
        a = 32'($urandom(32'd77));
        for (int r = 0; r < 40; r++) begin
            int nf = 1 + int'($urandom % 6);
            a = $urandom & 32'h00FF_FFFE;
            for (int k = 0; k < nf; k++) begin
                longint l = longint'($urandom % 32'h3000) & ~longint'(1);
                if (($urandom % 8) == 0) l = longint'($urandom % 32'h18000) & ~longint'(1);
                if (($urandom % 6) == 0) l = 0;
                add(a, l);
                if (($urandom % 2) == 0) a = a + 32'(l);
                else a = $urandom & 32'h00FF_FFFE;
            end
            run_req("R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule